// File: doc/BRIEF.md
# Posted Write Pending Tracker

This block is the bus-side front end for a peripheral whose working registers are clocked by a separate, slower functional clock that has no fixed relation to the bus clock. Ten working registers are carried across the clock boundary. Each one has its own toggle request/acknowledge handshake and a pending flag, and all ten flags can be read in one status word. Two more registers stay in the bus domain: the status word itself and an interface control word. Neither of them ever waits.

A mode bit in the interface control word selects how writes behave. In posted mode, which is the reset default, a write to a working register completes in the same cycle it is presented. Its pending flag then stays set until the functional domain has applied the value. Any later read or write of that register is held off until the flag clears. In stalling mode the bus is held with ready low until the value has been applied, so software never sees the flag set. Register 3 is a trigger: a write to it produces a single functional-clock pulse and stores nothing.

The bus controller is a three-state machine:
- `ST_IDLE` serves accesses.
- `ST_WAIT_FREE` holds an access whose target is still pending.
- `ST_WAIT_APPLY` holds a stalling-mode write until its acknowledge returns.

The transitions are:
- IDLE→WAIT_FREE and WAIT_FREE→WAIT_FREE: the target is busy.
- IDLE or WAIT_FREE → IDLE: the access is served.
- IDLE or WAIT_FREE → WAIT_APPLY: a stalling-mode write is launched.
- WAIT_APPLY→IDLE: the acknowledge has returned.
- WAIT_FREE→IDLE: the request is withdrawn.

The bus master holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until it samples `bus_ready` high at a rising edge.

Top module: `posted_wr_tracker`

## Requirements
- R1: After reset the interface control word reads 0x4 (posted mode), the status word reads 0, every functional register output is 0 and `fn_trig` is low.
- R2: Status word (address 10) bit i is the pending flag of working register at address i: 0 control, 1 counter, 2 load, 3 trigger, 4 match, 5 positive increment, 6 negative increment, 7 count value, 8 interrupt mask set, 9 interrupt mask count; bits 31:10 read 0.
- R3: In posted mode a write to a working register whose flag is clear completes with no stall and sets that flag, visible from the next cycle.
- R4: The written value appears on that register's slot of `fn_regs` (slot i at bits 32i+31:32i) before its pending flag clears.
- R5: Any access to a working register whose pending flag is set is stalled (`bus_ready` low) until the flag clears, and is then served.
- R6: Addresses 10 through 15 never stall; addresses 12 to 15 read 0 and ignore writes.
- R7: Interface control bit 2 selects posted mode (1) or stalling mode (0), is writable and reads back.
- R8: In stalling mode a working-register write holds `bus_ready` low until the value is on `fn_regs`; a status read right after it shows that flag clear.
- R9: A write to address 3 produces exactly one functional-clock cycle of `fn_trig` high; its `fn_regs` slot stays 0 and it reads back 0.
- R10: A read of a working register returns the last value written to it.
- R11: Writes to the status word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| fn_clk | input | 1 | Functional clock |
| fn_rst_n | input | 1 | Functional-domain asynchronous reset, active low |
| bus_req | input | 1 | Access request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Word address |
| bus_wdata | input | DW (32) | Write data |
| bus_ready | output | 1 | Access completes at this rising edge |
| bus_rdata | output | DW (32) | Read data, valid while ready is high |
| fn_regs | output | 10*DW | Applied register values, slot i for address i |
| fn_trig | output | 1 | One-cycle trigger pulse in the functional domain |

## Verification
If the tracker holds a stuck or stale pending flag, the error shows in two places. The status word reads wrong on the very next access, and every later access to that register hangs with ready low. If a handshake loses a toggle, the value on `fn_regs` never changes and the flag never clears, which polling exposes within a few hundred nanoseconds. The bench spaces back-to-back writes and reads so that the round trip of roughly three functional cycles is still in flight. That makes a wrong stall decision visible as a stall count of zero or nonzero. The trigger pulse is counted in both edges and high cycles, so a double or stuck pulse appears at once.

// File: rtl/ptrk_pkg.sv
package ptrk_pkg;
    localparam int NREG       = 10;
    localparam int TRIG_IDX   = 3;
    localparam int STAT_ADDR  = 10;
    localparam int IFC_ADDR   = 11;
    localparam int POSTED_BIT = 2;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_FREE  = 2'd1,
        ST_WAIT_APPLY = 2'd2
    } bus_state_e;
endpackage

// File: rtl/ptrk_sync.sv
module ptrk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ptrk_hs.sv
module ptrk_hs #(
    parameter int SYNC = 2
) (
    input  logic bclk,
    input  logic brst_n,
    input  logic launch,
    output logic pend,
    input  logic fclk,
    input  logic frst_n,
    output logic f_edge
);
    logic req_t, req_f, seen_q, ack_b;

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n)     req_t <= 1'b0;
        else if (launch) req_t <= ~req_t;
    end

    ptrk_sync #(.STAGES(SYNC)) u_req_sync (
        .clk(fclk), .rst_n(frst_n), .d(req_t), .q(req_f)
    );

    always_ff @(posedge fclk or negedge frst_n) begin
        if (!frst_n) seen_q <= 1'b0;
        else         seen_q <= req_f;
    end

    assign f_edge = req_f ^ seen_q;

    ptrk_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk(bclk), .rst_n(brst_n), .d(seen_q), .q(ack_b)
    );

    assign pend = req_t ^ ack_b;

    // R5: a new toggle is never issued while one is in flight
    p_no_relaunch_r5: assert property (@(posedge bclk) disable iff (!brst_n)
        launch |-> !pend);

    // R3: launching always leaves the flag set on the next bus cycle
    p_launch_sets_pend_r3: assert property (@(posedge bclk) disable iff (!brst_n)
        launch |=> pend);

    // R9: the functional side sees each request as one single-cycle edge
    p_edge_single_r9: assert property (@(posedge fclk) disable iff (!frst_n)
        f_edge |=> !f_edge);
endmodule

// File: rtl/ptrk_reg.sv
module ptrk_reg #(
    parameter int DW   = 32,
    parameter int SYNC = 2
) (
    input  logic          bclk,
    input  logic          brst_n,
    input  logic          launch,
    input  logic [DW-1:0] wdata,
    output logic          pend,
    output logic [DW-1:0] rb,
    input  logic          fclk,
    input  logic          frst_n,
    output logic [DW-1:0] fval
);
    logic [DW-1:0] hold_q;
    logic          f_edge;

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n)     hold_q <= '0;
        else if (launch) hold_q <= wdata;
    end

    ptrk_hs #(.SYNC(SYNC)) u_hs (
        .bclk(bclk), .brst_n(brst_n), .launch(launch), .pend(pend),
        .fclk(fclk), .frst_n(frst_n), .f_edge(f_edge)
    );

    always_ff @(posedge fclk or negedge frst_n) begin
        if (!frst_n)     fval <= '0;
        else if (f_edge) fval <= hold_q;
    end

    assign rb = hold_q;

    // R4: crossing data stays frozen while the transfer is in flight
    p_hold_stable_r4: assert property (@(posedge bclk) disable iff (!brst_n)
        pend |=> $stable(hold_q));

    // R4: the functional copy takes the held value on the request edge
    p_apply_value_r4: assert property (@(posedge fclk) disable iff (!frst_n)
        f_edge |=> (fval == $past(hold_q)));
endmodule

// File: rtl/ptrk_bus.sv
module ptrk_bus
    import ptrk_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic                     ifc_wbit,
    input  logic [NREG-1:0]          pend,
    input  logic [NREG-1:0][DW-1:0]  rb,
    output logic                     ready,
    output logic [DW-1:0]            rdata,
    output logic [NREG-1:0]          launch
);
    bus_state_e      state_q, state_d;
    logic            posted_q;
    logic            tracked;
    logic [NREG-1:0] sel;
    logic            busy;

    assign tracked = (int'(addr) < NREG);
    assign sel     = tracked ? (NREG'(1) << addr) : '0;
    assign busy    = |(sel & pend);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ready   = 1'b0;
        launch  = '0;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_WAIT_FREE: begin
                if (!req) begin
                    state_d = ST_IDLE;
                end else if (busy) begin
                    state_d = ST_WAIT_FREE;
                end else if (we && tracked && !posted_q) begin
                    launch  = sel;
                    state_d = ST_WAIT_APPLY;
                end else begin
                    ready   = 1'b1;
                    launch  = we ? sel : '0;
                    state_d = ST_IDLE;
                end
            end
            ST_WAIT_APPLY: begin
                if (!busy) begin
                    ready   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            posted_q <= 1'b1;
        else if (req && ready && we && addr == AW'(IFC_ADDR))
            posted_q <= ifc_wbit;
    end

    always_comb begin
        rdata = '0;
        if (tracked)
            rdata = rb[addr];
        else if (addr == AW'(STAT_ADDR))
            rdata[NREG-1:0] = pend;
        else if (addr == AW'(IFC_ADDR))
            rdata[POSTED_BIT] = posted_q;
    end

    // R5: an access aimed at a pending register is never completed
    p_stall_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && busy) |-> !ready);

    // R2: at most one crossing is started per cycle
    p_launch_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(launch));

    // R8: a stalling-mode write finishes with its flag already clear
    p_stall_mode_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_APPLY && ready) |-> ((sel & pend) == '0));

    // R6: untracked addresses complete in the cycle they are presented
    p_untracked_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !tracked && state_q == ST_IDLE) |-> ready);
endmodule

// File: rtl/posted_wr_tracker.sv
module posted_wr_tracker
    import ptrk_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               bus_clk,
    input  logic               bus_rst_n,
    input  logic               fn_clk,
    input  logic               fn_rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic               bus_ready,
    output logic [DW-1:0]      bus_rdata,
    output logic [NREG*DW-1:0] fn_regs,
    output logic               fn_trig
);
    logic [NREG-1:0]          pend;
    logic [NREG-1:0]          launch;
    logic [NREG-1:0][DW-1:0]  rb;
    logic [NREG-1:0][DW-1:0]  fv;
    logic                     trig_q;

    ptrk_bus #(.DW(DW), .AW(AW)) u_bus (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .req(bus_req), .we(bus_we), .addr(bus_addr),
        .ifc_wbit(bus_wdata[POSTED_BIT]),
        .pend(pend), .rb(rb),
        .ready(bus_ready), .rdata(bus_rdata), .launch(launch)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_lane
        if (g == TRIG_IDX) begin : g_pulse
            logic f_edge;
            ptrk_hs #(.SYNC(SYNC_STAGES)) u_hs (
                .bclk(bus_clk), .brst_n(bus_rst_n), .launch(launch[g]),
                .pend(pend[g]), .fclk(fn_clk), .frst_n(fn_rst_n),
                .f_edge(f_edge)
            );
            always_ff @(posedge fn_clk or negedge fn_rst_n) begin
                if (!fn_rst_n) trig_q <= 1'b0;
                else           trig_q <= f_edge;
            end
            assign rb[g] = '0;
            assign fv[g] = '0;
        end else begin : g_store
            ptrk_reg #(.DW(DW), .SYNC(SYNC_STAGES)) u_reg (
                .bclk(bus_clk), .brst_n(bus_rst_n), .launch(launch[g]),
                .wdata(bus_wdata), .pend(pend[g]), .rb(rb[g]),
                .fclk(fn_clk), .frst_n(fn_rst_n), .fval(fv[g])
            );
        end
    end

    assign fn_regs = fv;
    assign fn_trig = trig_q;

    // R9: the trigger output is never high on two functional cycles in a row
    p_trig_one_cycle_r9: assert property (@(posedge fn_clk) disable iff (!fn_rst_n)
        fn_trig |=> !fn_trig);
endmodule

// File: tb/posted_wr_tracker_test.sv
module posted_wr_tracker_test;
    logic        bus_clk = 0, fn_clk = 0;
    logic        bus_rst_n = 0, fn_rst_n = 0;
    logic        bus_req = 0, bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [319:0] fn_regs;
    logic        fn_trig;

    int tests = 0, fails = 0;
    bit done = 0;
    bit chk_active = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    int trig_hi = 0, trig_rise = 0;
    logic trig_prev = 0;

    always #10 bus_clk = ~bus_clk;
    always #37 fn_clk  = ~fn_clk;

    posted_wr_tracker uut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .fn_clk(fn_clk), .fn_rst_n(fn_rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .fn_regs(fn_regs), .fn_trig(fn_trig)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected read data as reads complete
    always @(negedge bus_clk) begin
        if (chk_active && bus_req && bus_ready && !bus_we) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL scoreboard: read with nothing expected, actual %h expected none", bus_rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, bus_rdata, e);
            end
        end
    end

    always @(negedge fn_clk) begin
        if (fn_trig) trig_hi++;
        if (fn_trig && !trig_prev) trig_rise++;
        trig_prev = fn_trig;
    end

    task automatic xfer(input logic we, input logic [3:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int stalls);
        bit got = 0;
        @(posedge bus_clk); #1;
        bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
        stalls = 0; rd = '0;
        while (!got && stalls < 5000) begin
            @(negedge bus_clk);
            if (bus_ready) begin rd = bus_rdata; got = 1; end
            else stalls++;
        end
        @(posedge bus_clk); #1;
        bus_req = 0; bus_we = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int stalls);
        logic [31:0] rd;
        xfer(1'b1, a, d, rd, stalls);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] e, input string tag,
                          output int stalls);
        logic [31:0] rd;
        exp_q.push_back(e); tag_q.push_back(tag);
        chk_active = 1;
        xfer(1'b0, a, 32'h0, rd, stalls);
        chk_active = 0;
    endtask

    task automatic poll_clear(input int b);
        logic [31:0] rd;
        int s;
        for (int k = 0; k < 200; k++) begin
            xfer(1'b0, 4'd10, 32'h0, rd, s);
            if (!rd[b]) break;
        end
        chk("R4 flag clears", {31'b0, rd[b]}, 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int s;
        int r0, h0;
        repeat (4) @(posedge bus_clk);
        bus_rst_n = 1; fn_rst_n = 1;
        repeat (2) @(posedge bus_clk);

        // R1 reset state
        chk("R1 fn_regs reset", {31'b0, (fn_regs == '0)}, 32'h1);
        chk("R1 fn_trig reset", {31'b0, fn_trig}, 32'h0);
        rd_chk(4'd11, 32'h4, "R1 R7 ifc reset posted", s);
        rd_chk(4'd10, 32'h0, "R1 status reset", s);

        // R3 posted write, R2 bit 0, R4 applied, R10 read back
        wr(4'd0, 32'hA5A5_0001, s);
        chk("R3 posted no stall", s, 0);
        rd_chk(4'd10, 32'h1, "R2 R3 control pending", s);
        poll_clear(0);
        chk("R4 control applied", fn_regs[31:0], 32'hA5A5_0001);
        rd_chk(4'd0, 32'hA5A5_0001, "R10 control readback", s);

        // R2 mapping of further bits
        wr(4'd7, 32'h7777_0007, s);
        rd_chk(4'd10, 32'h80, "R2 count value bit 7", s);
        poll_clear(7);
        chk("R4 count value applied", fn_regs[7*32 +: 32], 32'h7777_0007);
        wr(4'd9, 32'h9999_0009, s);
        rd_chk(4'd10, 32'h200, "R2 mask count bit 9", s);
        poll_clear(9);

        // R2 two flags at once
        wr(4'd5, 32'h5, s);
        wr(4'd6, 32'h6, s);
        rd_chk(4'd10, 32'h60, "R2 bits 5 and 6", s);
        poll_clear(5); poll_clear(6);
        chk("R4 pos inc applied", fn_regs[5*32 +: 32], 32'h5);

        // R5 write to a pending register stalls, then lands
        wr(4'd1, 32'h1111_0001, s);
        wr(4'd1, 32'h1111_0002, s);
        chk("R5 write stall count nonzero", {31'b0, (s > 0)}, 32'h1);
        poll_clear(1);
        chk("R5 second value applied", fn_regs[32 +: 32], 32'h1111_0002);
        rd_chk(4'd1, 32'h1111_0002, "R10 counter readback", s);

        // R5 read of a pending register stalls
        wr(4'd2, 32'h2222_0002, s);
        rd_chk(4'd2, 32'h2222_0002, "R5 R10 load read after stall", s);
        chk("R5 read stall count nonzero", {31'b0, (s > 0)}, 32'h1);
        chk("R4 load applied before read", fn_regs[64 +: 32], 32'h2222_0002);

        // R6 unused addresses, R11 status read-only
        wr(4'd12, 32'hDEAD_BEEF, s);
        chk("R6 unused write no stall", s, 0);
        rd_chk(4'd12, 32'h0, "R6 unused reads zero", s);
        chk("R6 unused read no stall", s, 0);
        wr(4'd10, 32'h3FF, s);
        rd_chk(4'd10, 32'h0, "R11 status write ignored", s);
        chk("R6 status no stall", s, 0);

        // R9 trigger pulse
        r0 = trig_rise; h0 = trig_hi;
        wr(4'd3, 32'hFFFF_FFFF, s);
        poll_clear(3);
        repeat (10) @(posedge bus_clk);
        chk("R9 one trigger edge", trig_rise, r0 + 1);
        chk("R9 one trigger cycle", trig_hi, h0 + 1);
        chk("R9 trigger slot zero", fn_regs[96 +: 32], 32'h0);
        rd_chk(4'd3, 32'h0, "R9 trigger reads zero", s);

        // R7 mode select, R8 stalling writes
        wr(4'd11, 32'h0, s);
        rd_chk(4'd11, 32'h0, "R7 stalling mode readback", s);
        wr(4'd4, 32'h4444_0004, s);
        chk("R8 stall until applied", {31'b0, (s > 2)}, 32'h1);
        chk("R8 value present at completion", fn_regs[128 +: 32], 32'h4444_0004);
        rd_chk(4'd10, 32'h0, "R8 no visible pending", s);
        wr(4'd8, 32'h8888_0008, s);
        rd_chk(4'd10, 32'h0, "R8 mask set no visible pending", s);
        chk("R8 mask set applied", fn_regs[256 +: 32], 32'h8888_0008);
        wr(4'd11, 32'h4, s);
        rd_chk(4'd11, 32'h4, "R7 posted mode restored", s);
        wr(4'd4, 32'h4444_0005, s);
        chk("R7 posted again no stall", s, 0);
        poll_clear(4);

        chk("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule